// File: doc/BRIEF.md
# Interrupt Distributor with Wide CPU Targets

This block gathers interrupt lines from peripherals and decides, per CPU interface, which sources are ready to be taken. A source is forwarded to a CPU when it is pending, enabled, aimed at that CPU and not already being serviced there, and only while the distributor as a whole is switched on. Software programs it through a 32-bit register port with plain read and write strobes; a side field on that port says which CPU is making the access, because the first 32 source IDs are private to each CPU and their enables, pending and active state are kept once per CPU.

IDs 0 to 15 are raised only by software through a single trigger write that carries a 16-bit CPU map and the ID. IDs 16 to 31 are per-CPU peripheral lines. IDs 32 and up are shared lines, each carrying a 16-bit target field so that two shared sources fill one 32-bit target word. Each CPU interface returns an acknowledge (the CPU starts servicing an ID) and an end-of-interrupt (it has finished), which move the per-CPU active state.

Top module: `irq_dist`

## Requirements
- R1: Bit 0 of the control word (offset 0x000) switches forwarding on; while it is 0 every `fwd` bit is 0, and pending state survives so that forwarding resumes when it returns to 1.
- R2: The read-only word at offset 0x004 returns in bits 4:0 a value v with (v+1)*32 covering the implemented sources (64 sources give 1); the line count is capped at 510.
- R3: Writing 1 to bit (n mod 32) of the word at 0x100 + 4*(n/32) enables source n; the same bit at 0x180 + 4*(n/32) disables it; zero bits change nothing. Both words read back the enable bits.
- R4: Enable bits of IDs 0 to 31 are held separately per CPU and the bank used is the one named on `bus_cpu`.
- R5: Shared source n owns a 16-bit target field in the word at 0x800 + ((2n) & ~3), bits 15:0 for even n and 31:16 for odd n; bit c of the field aims the source at CPU c.
- R6: Target words for IDs 0 to 31 read back, in both halves, only the bit of the CPU on `bus_cpu`; writes to them are ignored.
- R7: Trigger type for source n is bit (n mod 32) of the word at 0x300 + 4*(n/32): 1 is rising edge, 0 is level high. Bits of IDs 0 to 15 always read 1 and ignore writes.
- R8: A write to 0x F00 with ID in bits 3:0 and CPU map in bits 23:8 sets that ID pending on every CPU whose map bit is 1.
- R9: A level source is pending while its input is high, except that it holds its state while active; an edge source becomes pending on a rising input and stays pending after the input falls.
- R10: `fwd[c*NUM_SRC+n]` is 1 exactly when source n is pending, enabled for CPU c, aimed at CPU c (IDs below 32 always aim at their own CPU), not active on CPU c, and R1 allows it.
- R11: An acknowledge from CPU c for an ID whose forward bit is 1 makes that ID active on CPU c and clears its pending state when it is edge-type or software-raised; an acknowledge for an ID not forwarded to c is ignored.
- R12: An end-of-interrupt from CPU c for ID n clears its active state on CPU c.
- R13: Peripheral lines 16 to 31 of one CPU reach only that CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | 4 | Index of the CPU making the access |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| ppi_in | input | NUM_CPU*16 | Private peripheral lines, 16 per CPU, IDs 16 to 31 |
| spi_in | input | NUM_SRC-32 | Shared lines, bit i is ID 32+i |
| cpu_ack | input | NUM_CPU | Per-CPU acknowledge strobe |
| cpu_ack_id | input | NUM_CPU*6 | Per-CPU acknowledged ID |
| cpu_eoi | input | NUM_CPU | Per-CPU end-of-interrupt strobe |
| cpu_eoi_id | input | NUM_CPU*6 | Per-CPU completed ID |
| fwd | output | NUM_CPU*NUM_SRC | Ready-to-take vector, bit c*NUM_SRC+n for CPU c and ID n |

## Verification
Every piece of state here lands on `fwd` one clock after the event that changes it, so a wrong enable bank, a target half swapped by parity, a lost edge or a stuck active bit shows as a missing or extra forward bit on the very next cycle. The directed scenarios therefore pair each register write, line change, acknowledge or completion with a look at the forward bits of every CPU one cycle later, including the CPUs that must stay quiet. Banked state is checked by asking the same question from two CPUs, and ignored writes or acknowledges by later making the untouched state visible through a target change.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int unsigned OFF_CTRL  = 'h000;
  localparam int unsigned OFF_TYPE  = 'h004;
  localparam int unsigned OFF_ENSET = 'h100;
  localparam int unsigned OFF_ENCLR = 'h180;
  localparam int unsigned OFF_TRIG  = 'h300;
  localparam int unsigned OFF_TGT   = 'h800;
  localparam int unsigned OFF_SGI   = 'hF00;

  localparam int unsigned LINE_CAP  = 510;
  localparam int unsigned NUM_PRIV  = 32;
  localparam int unsigned NUM_SGI   = 16;
  localparam int unsigned TGT_W     = 16;
  localparam int unsigned CPU_W     = 4;

  // byte offset of the target word holding source n
  function automatic int unsigned tgt_word_off(int unsigned n);
    return OFF_TGT + ((2 * n) & ~32'd3);
  endfunction

  // odd sources sit in the upper half of their target word
  function automatic bit tgt_upper(int unsigned n);
    return (n % 2) == 1;
  endfunction

  // value reported in the type word, after the line cap
  function automatic logic [4:0] type_field(int unsigned nsrc);
    int unsigned lines;
    lines = (nsrc > LINE_CAP) ? LINE_CAP : nsrc;
    return 5'(((lines + 31) / 32) - 1);
  endfunction

endpackage

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_wr,
  input  logic                                 bus_rd,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [31:0]                          bus_wdata,
  input  logic [CPU_W-1:0]                     bus_cpu,
  output logic [31:0]                          bus_rdata,
  output logic                                 ctrl_en,
  output logic [NUM_CPU-1:0][NUM_PRIV-1:0]     en_priv,
  output logic [NUM_SRC-1:NUM_PRIV]            en_spi,
  output logic [NUM_SRC-1:NUM_SGI]             trig,
  output logic [NUM_SRC-1:NUM_PRIV][TGT_W-1:0] tgt,
  output logic [NUM_CPU-1:0][NUM_SGI-1:0]      sgi_set
);

  localparam int unsigned NWORD  = NUM_SRC / 32;
  localparam int unsigned NTWORD = NUM_SRC / 2;

  logic [ADDR_W-1:0] a;
  logic [1:0]        unused_lsb;
  assign a          = {bus_addr[ADDR_W-1:2], 2'b00};
  assign unused_lsb = bus_addr[1:0];

  logic                                 ctrl_q;
  logic [NUM_CPU-1:0][NUM_PRIV-1:0]     en_priv_q;
  logic [NUM_SRC-1:NUM_PRIV]            en_spi_q;
  logic [NUM_SRC-1:NUM_SGI]             trig_q;
  logic [NUM_SRC-1:NUM_PRIV][TGT_W-1:0] tgt_q;
  logic [NUM_SRC-1:0][TGT_W-1:0]        tgt_view;
  logic [TGT_W-1:0]                     own_bit;

  assign own_bit = TGT_W'(1) << bus_cpu;

  // private target fields are synthesised from the requesting CPU
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_tview
    if (n < NUM_PRIV) begin : g_p
      assign tgt_view[n] = own_bit;
    end else begin : g_s
      assign tgt_view[n] = tgt_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= 1'b0;
      en_priv_q <= '0;
      en_spi_q  <= '0;
      trig_q    <= '0;
      tgt_q     <= '0;
    end else if (bus_wr) begin
      if (a == ADDR_W'(OFF_CTRL)) ctrl_q <= bus_wdata[0];
      for (int c = 0; c < NUM_CPU; c++) begin
        if (bus_cpu == CPU_W'(c)) begin
          if (a == ADDR_W'(OFF_ENSET)) en_priv_q[c] <= en_priv_q[c] | bus_wdata;
          if (a == ADDR_W'(OFF_ENCLR)) en_priv_q[c] <= en_priv_q[c] & ~bus_wdata;
        end
      end
      for (int w = 1; w < NWORD; w++) begin
        if (a == ADDR_W'(OFF_ENSET + 4 * w))
          en_spi_q[w*32 +: 32] <= en_spi_q[w*32 +: 32] | bus_wdata;
        if (a == ADDR_W'(OFF_ENCLR + 4 * w))
          en_spi_q[w*32 +: 32] <= en_spi_q[w*32 +: 32] & ~bus_wdata;
        if (a == ADDR_W'(OFF_TRIG + 4 * w))
          trig_q[w*32 +: 32] <= bus_wdata;
      end
      // software IDs keep their fixed type: only the upper half is writable
      if (a == ADDR_W'(OFF_TRIG)) trig_q[31:16] <= bus_wdata[31:16];
      for (int n = NUM_PRIV; n < NUM_SRC; n++) begin
        if (a == ADDR_W'(tgt_word_off(n)))
          tgt_q[n] <= tgt_upper(n) ? bus_wdata[31:16] : bus_wdata[15:0];
      end
    end
  end

  // software trigger decode: one pulse per (cpu, id)
  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int k = 0; k < NUM_SGI; k++) begin
        sgi_set[c][k] = bus_wr && (a == ADDR_W'(OFF_SGI)) && bus_wdata[8+c]
                        && (bus_wdata[3:0] == 4'(k));
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (a == ADDR_W'(OFF_CTRL)) bus_rdata = {31'b0, ctrl_q};
      if (a == ADDR_W'(OFF_TYPE)) bus_rdata = {27'b0, type_field(NUM_SRC)};
      if (a == ADDR_W'(OFF_ENSET) || a == ADDR_W'(OFF_ENCLR)) begin
        for (int c = 0; c < NUM_CPU; c++)
          if (bus_cpu == CPU_W'(c)) bus_rdata = en_priv_q[c];
      end
      if (a == ADDR_W'(OFF_TRIG)) bus_rdata = {trig_q[31:16], 16'hFFFF};
      for (int w = 1; w < NWORD; w++) begin
        if (a == ADDR_W'(OFF_ENSET + 4 * w) || a == ADDR_W'(OFF_ENCLR + 4 * w))
          bus_rdata = en_spi_q[w*32 +: 32];
        if (a == ADDR_W'(OFF_TRIG + 4 * w))
          bus_rdata = trig_q[w*32 +: 32];
      end
      for (int t = 0; t < NTWORD; t++) begin
        if (a == ADDR_W'(OFF_TGT + 4 * t))
          bus_rdata = {tgt_view[2*t+1], tgt_view[2*t]};
      end
    end
  end

  assign ctrl_en = ctrl_q;
  assign en_priv = en_priv_q;
  assign en_spi  = en_spi_q;
  assign trig    = trig_q;
  assign tgt     = tgt_q;

  // R3: set bank turns bits on, clear bank turns them off (word 1)
  if (NWORD > 1) begin : g_chk_en
    a_r3_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a == ADDR_W'(OFF_ENSET + 4))
      |=> ((en_spi_q[32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));
    a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && a == ADDR_W'(OFF_ENCLR + 4))
      |=> ((en_spi_q[32 +: 32] & $past(bus_wdata)) == 32'd0));
  end

  // R6: a private target word names exactly the reader, in both halves
  a_r6_own_target: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && a == ADDR_W'(OFF_TGT) && bus_cpu < CPU_W'(NUM_CPU))
    |-> ($countones(bus_rdata) == 2 && bus_rdata[15:0] == bus_rdata[31:16]));

endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:NUM_SGI]         trig,
  input  logic [NUM_CPU-1:0][15:0]         ppi_in,
  input  logic [NUM_SRC-1:NUM_PRIV]        spi_in,
  input  logic [NUM_CPU-1:0][NUM_SGI-1:0]  sgi_set,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  ack_take,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]  eoi_hit,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]  pend,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]  act
);

  logic [NUM_CPU-1:0][NUM_PRIV-1:0] ppend_q, ppend_d;
  logic [NUM_CPU-1:0][15:0]         ppi_prev_q;
  logic [NUM_SRC-1:NUM_PRIV]        spend_q, spend_d, spi_prev_q;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]  act_q, act_d;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int k = 0; k < NUM_SGI; k++)
        ppend_d[c][k] = sgi_set[c][k] | (ppend_q[c][k] & ~ack_take[c][k]);
      for (int k = NUM_SGI; k < NUM_PRIV; k++) begin
        if (trig[k])
          ppend_d[c][k] = (ppi_in[c][k-NUM_SGI] & ~ppi_prev_q[c][k-NUM_SGI])
                          | (ppend_q[c][k] & ~ack_take[c][k]);
        else
          ppend_d[c][k] = act_q[c][k] ? ppend_q[c][k] : ppi_in[c][k-NUM_SGI];
      end
    end
    for (int n = NUM_PRIV; n < NUM_SRC; n++) begin
      logic any_act, any_ack;
      any_act = 1'b0;
      any_ack = 1'b0;
      for (int c = 0; c < NUM_CPU; c++) begin
        any_act = any_act | act_q[c][n];
        any_ack = any_ack | ack_take[c][n];
      end
      if (trig[n])
        spend_d[n] = (spi_in[n] & ~spi_prev_q[n]) | (spend_q[n] & ~any_ack);
      else
        spend_d[n] = any_act ? spend_q[n] : spi_in[n];
    end
    act_d = (act_q & ~eoi_hit) | ack_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppend_q    <= '0;
      ppi_prev_q <= '0;
      spend_q    <= '0;
      spi_prev_q <= '0;
      act_q      <= '0;
    end else begin
      ppend_q    <= ppend_d;
      ppi_prev_q <= ppi_in;
      spend_q    <= spend_d;
      spi_prev_q <= spi_in;
      act_q      <= act_d;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_view
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      if (n < NUM_PRIV) begin : g_p
        assign pend[c][n] = ppend_q[c][n];
      end else begin : g_s
        assign pend[c][n] = spend_q[n];
      end
      // R12: completion clears the active bit unless a new acknowledge lands
      a_r12_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit[c][n] && !ack_take[c][n]) |=> !act_q[c][n]);
    end
    for (genvar k = 0; k < NUM_SGI; k++) begin : g_sgi
      // R8: a software trigger always leaves the ID pending on its CPU
      a_r8_sgi_lands: assert property (@(posedge clk) disable iff (!rst_n)
        sgi_set[c][k] |=> ppend_q[c][k]);
    end
  end

  for (genvar n = NUM_PRIV; n < NUM_SRC; n++) begin : g_edge
    // R9: a rising edge on an edge-type shared line is never lost
    a_r9_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[n] && spi_in[n] && !spi_prev_q[n]) |=> spend_q[n]);
  end

  assign act = act_q;

endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
  input  logic                                 ctrl_en,
  input  logic [NUM_CPU-1:0][NUM_PRIV-1:0]     en_priv,
  input  logic [NUM_SRC-1:NUM_PRIV]            en_spi,
  input  logic [NUM_SRC-1:NUM_PRIV][TGT_W-1:0] tgt,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]      pend,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]      act,
  input  logic [NUM_CPU-1:0]                   cpu_ack,
  input  logic [NUM_CPU-1:0][ID_W-1:0]         cpu_ack_id,
  input  logic [NUM_CPU-1:0]                   cpu_eoi,
  input  logic [NUM_CPU-1:0][ID_W-1:0]         cpu_eoi_id,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]      fwd,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]      ack_take,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]      eoi_hit
);

  logic [NUM_TGT_UNUSED_W-1:0] unused_tgt_hi;
  localparam int unsigned NUM_TGT_UNUSED_W = 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic aimed, enabled;
      if (n < NUM_PRIV) begin : g_p
        assign aimed   = 1'b1;
        assign enabled = en_priv[c][n];
      end else begin : g_s
        assign aimed   = tgt[n][c];
        assign enabled = en_spi[n];
      end
      assign fwd[c][n]      = ctrl_en & pend[c][n] & enabled & aimed & ~act[c][n];
      assign ack_take[c][n] = cpu_ack[c] && (cpu_ack_id[c] == ID_W'(n)) && fwd[c][n];
      assign eoi_hit[c][n]  = cpu_eoi[c] && (cpu_eoi_id[c] == ID_W'(n));
    end
  end

  // target bits above the CPU count never steer anything
  assign unused_tgt_hi = ^tgt;

endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned ID_W    = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [CPU_W-1:0]           bus_cpu,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_CPU*16-1:0]      ppi_in,
  input  logic [NUM_SRC-33:0]        spi_in,
  input  logic [NUM_CPU-1:0]         cpu_ack,
  input  logic [NUM_CPU*ID_W-1:0]    cpu_ack_id,
  input  logic [NUM_CPU-1:0]         cpu_eoi,
  input  logic [NUM_CPU*ID_W-1:0]    cpu_eoi_id,
  output logic [NUM_CPU*NUM_SRC-1:0] fwd
);

  logic                                 ctrl_en;
  logic [NUM_CPU-1:0][NUM_PRIV-1:0]     en_priv;
  logic [NUM_SRC-1:NUM_PRIV]            en_spi;
  logic [NUM_SRC-1:NUM_SGI]             trig;
  logic [NUM_SRC-1:NUM_PRIV][TGT_W-1:0] tgt;
  logic [NUM_CPU-1:0][NUM_SGI-1:0]      sgi_set;
  logic [NUM_CPU-1:0][NUM_SRC-1:0]      pend, act, fwd_v, ack_take, eoi_hit;
  logic [NUM_CPU-1:0][15:0]             ppi_v;
  logic [NUM_SRC-1:NUM_PRIV]            spi_v;
  logic [NUM_CPU-1:0][ID_W-1:0]         ack_id_v, eoi_id_v;

  assign ppi_v    = ppi_in;
  assign spi_v    = spi_in;
  assign ack_id_v = cpu_ack_id;
  assign eoi_id_v = cpu_eoi_id;
  assign fwd      = fwd_v;

  irq_dist_regs #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .ctrl_en(ctrl_en), .en_priv(en_priv),
    .en_spi(en_spi), .trig(trig), .tgt(tgt), .sgi_set(sgi_set)
  );

  irq_dist_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ppi_in(ppi_v), .spi_in(spi_v),
    .sgi_set(sgi_set), .ack_take(ack_take), .eoi_hit(eoi_hit),
    .pend(pend), .act(act)
  );

  irq_dist_route #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_route (
    .ctrl_en(ctrl_en), .en_priv(en_priv), .en_spi(en_spi), .tgt(tgt),
    .pend(pend), .act(act), .cpu_ack(cpu_ack), .cpu_ack_id(ack_id_v),
    .cpu_eoi(cpu_eoi), .cpu_eoi_id(eoi_id_v), .fwd(fwd_v),
    .ack_take(ack_take), .eoi_hit(eoi_hit)
  );

  // R1: switching the distributor off silences every CPU on the next cycle
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[0]) |=> (fwd == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      // R11: an ID only turns active on a CPU it was offered to
      a_r11_active_from_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act[c][n]) |-> $past(fwd_v[c][n]));
      // R10: an active ID is never offered again to the same CPU
      a_r10_active_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (act[c][n] && $past(act[c][n]) && !$past(eoi_hit[c][n])) |-> !fwd_v[c][n]);
    end
  end

endmodule

// File: tb/test_irq_dist.sv
module test_irq_dist;
  localparam int NS = 64;
  localparam int NC = 4;
  localparam int IW = 6;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NC*16-1:0] ppi_in = '0;
  logic [NS-33:0]   spi_in = '0;
  logic [NC-1:0]    cpu_ack = '0, cpu_eoi = '0;
  logic [NC*IW-1:0] cpu_ack_id = '0, cpu_eoi_id = '0;
  logic [NC*NS-1:0] fwd;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist i_irq_dist (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .ppi_in(ppi_in), .spi_in(spi_in),
    .cpu_ack(cpu_ack), .cpu_ack_id(cpu_ack_id), .cpu_eoi(cpu_eoi),
    .cpu_eoi_id(cpu_eoi_id), .fwd(fwd)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic fb(int c, int n);
    return fwd[c*NS + n];
  endfunction

  task automatic wr(logic [11:0] ad, logic [31:0] d, logic [3:0] cpu = 0);
    @(negedge clk);
    bus_wr = 1; bus_addr = ad; bus_wdata = d; bus_cpu = cpu;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] ad, logic [3:0] cpu, output logic [31:0] d);
    bus_rd = 1; bus_addr = ad; bus_cpu = cpu;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic ack(int c, int id);
    @(negedge clk);
    cpu_ack[c] = 1; cpu_ack_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    cpu_ack[c] = 0;
  endtask

  task automatic eoi(int c, int id);
    @(negedge clk);
    cpu_eoi[c] = 1; cpu_eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk);
    cpu_eoi[c] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 reset fwd empty", 32'(fwd != '0), 0);
    rd(12'h000, 0, d); chk("R1 ctrl reset", d, 0);
    rd(12'h004, 0, d); chk("R2 type field", d, 32'd1);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(12'h104, 32'h300);
    rd(12'h104, 0, d); chk("R3 set bank", d, 32'h300);
    wr(12'h184, 32'h200);
    rd(12'h104, 0, d); chk("R3 clear bank", d, 32'h100);
    wr(12'h104, 32'h0); wr(12'h184, 32'h0);
    rd(12'h184, 0, d); chk("R3 zero writes no effect", d, 32'h100);
    wr(12'h104, 32'h200);
    rd(12'h104, 0, d); chk("R3 re-enable", d, 32'h300);
  endtask

  task automatic t_banked();
    logic [31:0] d;
    wr(12'h100, 32'h20, 0);
    rd(12'h100, 2, d); chk("R4 other bank untouched", d, 0);
    rd(12'h100, 0, d); chk("R4 own bank", d, 32'h20);
  endtask

  task automatic t_targets();
    logic [31:0] d;
    wr(12'h850, 32'h0004_0002);
    rd(12'h850, 0, d); chk("R5 target word pair", d, 32'h0004_0002);
  endtask

  task automatic t_private_tgt();
    logic [31:0] d;
    rd(12'h800, 2, d); chk("R6 private target cpu2", d, 32'h0004_0004);
    wr(12'h800, 32'h0);
    rd(12'h800, 1, d); chk("R6 private target write ignored", d, 32'h0002_0002);
    rd(12'h83C, 3, d); chk("R6 private target ids 30/31", d, 32'h0008_0008);
  endtask

  task automatic t_trig();
    logic [31:0] d;
    wr(12'h300, 32'h0);
    rd(12'h300, 0, d); chk("R7 software ids fixed type", d, 32'h0000_FFFF);
    wr(12'h304, 32'h200);
    rd(12'h304, 0, d); chk("R7 shared type word", d, 32'h200);
  endtask

  task automatic t_level_route();
    wr(12'h000, 32'h1);
    @(negedge clk); spi_in[8] = 1;
    @(negedge clk);
    chk("R10 level forwarded to cpu1", 32'(fb(1, 40)), 1);
    chk("R10 not aimed at cpu0", 32'(fb(0, 40)), 0);
    chk("R5 even source low half only", 32'(fb(2, 40)), 0);
    wr(12'h000, 32'h0);
    chk("R1 disabled silences", 32'(fwd != '0), 0);
    wr(12'h000, 32'h1);
    chk("R1 pending survives disable", 32'(fb(1, 40)), 1);
    @(negedge clk); spi_in[8] = 0;
    @(negedge clk);
    chk("R9 level follows input", 32'(fb(1, 40)), 0);
  endtask

  task automatic t_edge();
    @(negedge clk); spi_in[9] = 1;
    @(negedge clk); spi_in[9] = 0;
    @(negedge clk);
    chk("R9 edge latched after fall", 32'(fb(2, 41)), 1);
    chk("R5 odd source high half", 32'(fb(1, 41)), 0);
  endtask

  task automatic t_ack();
    ack(2, 41);
    chk("R11 ack hides edge source", 32'(fb(2, 41)), 0);
    eoi(2, 41);
    chk("R11 edge pending cleared by ack", 32'(fb(2, 41)), 0);
    @(negedge clk); spi_in[8] = 1;
    @(negedge clk);
    chk("R9 level raised again", 32'(fb(1, 40)), 1);
    ack(1, 40);
    chk("R10 active not forwarded", 32'(fb(1, 40)), 0);
    ack(3, 40);
    eoi(1, 40);
    wr(12'h850, 32'h0004_000A);
    chk("R12 eoi reopens cpu1", 32'(fb(1, 40)), 1);
    chk("R11 stray ack ignored", 32'(fb(3, 40)), 1);
    @(negedge clk); spi_in[8] = 0;
  endtask

  task automatic t_sgi();
    wr(12'hF00, (32'h5 << 8) | 32'h5);
    chk("R8 sgi on cpu0", 32'(fb(0, 5)), 1);
    chk("R8 sgi not on cpu1", 32'(fb(1, 5)), 0);
    chk("R4 cpu2 sgi held by its own enable", 32'(fb(2, 5)), 0);
    wr(12'h100, 32'h20, 2);
    chk("R4 cpu2 bank enable releases", 32'(fb(2, 5)), 1);
    ack(0, 5);
    chk("R11 sgi ack clears cpu0", 32'(fb(0, 5)), 0);
    chk("R11 sgi cpu2 untouched", 32'(fb(2, 5)), 1);
  endtask

  task automatic t_ppi();
    wr(12'h100, 32'h0010_0000, 3);
    wr(12'h100, 32'h0010_0000, 1);
    @(negedge clk); ppi_in[3*16 + 4] = 1;
    @(negedge clk);
    chk("R13 private line on cpu3", 32'(fb(3, 20)), 1);
    chk("R13 private line not on cpu1", 32'(fb(1, 20)), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_banked();
    t_targets();
    t_private_tgt();
    t_trig();
    t_level_route();
    t_edge();
    t_ack();
    t_sgi();
    t_ppi();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule